// File: doc/BRIEF.md
# Compare-Driven Timer Channel

This block is one 16-bit up-counting timer channel with a small register port. A selectable time base drives the counter. The time base is the system clock, one of two prescaled versions of it, or the rising edges of an asynchronous external line. Two compare registers, A and C, watch the counter. C can be set to restart the count, which gives a periodic event. C can instead be set to halt the count, which gives a one-shot delay.

The same compare events latch status flags that drive one maskable interrupt line. They can also set and clear a single waveform output. This output can produce a square wave with a programmable edge position. With A at zero and C at half range in free-running mode, it gives a 50% duty wave with one rising edge per wrap.

Software starts, stops and restarts the channel through a command register. It reads the live count back with no added latency.

Top module: `tmr_chan`

## Requirements
- R1: When the mode bits select neither restart nor halt on C, the counter counts every tick from 0 through 0xFFFF and then returns to 0, whatever value C holds.
- R2: With the restart bit (mode bit 2) set, the tick after the count equals C returns it to 0, so the count sequence repeats every C+1 ticks.
- R3: With the halt bit (mode bit 3) set, the tick that brings the count to C sets the C flag and stops the channel, and the count then holds at C.
- R4: A command write with the trigger bit (bit 2) zeroes both the count and the prescaler at once. Together with the enable bit (bit 0) it starts a stopped channel. On its own it leaves a stopped channel stopped.
- R5: Command bit 0 enables counting and bit 1 disables it. When both are written together, disable wins and the count stays frozen.
- R6: Writing ones to address 5 unmasks interrupt sources and writing ones to address 6 masks them (bit 0 = A flag, bit 1 = C flag). irq_o is high exactly while some unmasked flag is latched. Writing 0xFF to address 6 drops irq_o on the next cycle.
- R7: When mode bit 4 is set, an A compare drives wave_o high. When mode bit 5 is set, a C compare drives it low. With A=0 and C=0x8000 in free-running mode, wave_o is low for counts 0x8000..0xFFFF and high for 0..0x7FFF.
- R8: A read of the status register (address 7: bit 0 A flag, bit 1 C flag, bit 2 running, bit 3 wave_o level) returns the flags and clears them. A compare in the same cycle as the read is still latched afterwards.
- R9: Compares are evaluated only when a tick advances the counter, never on the zeroing caused by a trigger. A new C value written while running applies from the next tick.
- R10: Mode bits [1:0] pick the time base: 0 = every cycle, 1 = every 4 cycles, 2 = every 16 cycles, 3 = each rising edge of ext_clk_i after a two-stage synchronizer. Counting starts aligned to the trigger.
- R11: After reset the count, flags, mask, wave_o and irq_o are 0. The count register (address 3) returns the current count combinationally. Addresses 0, 1 and 2 hold mode, compare A and compare C, and address 4 takes commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears flags at address 7) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data, combinational from address |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| irq_o | output | 1 | Compare interrupt |
| wave_o | output | 1 | Compare-driven waveform output |

## Verification
A corrupted count shows on the count register in the same cycle it happens. A wrong restart or halt decision appears one tick later, as a count that fails to return to zero or fails to hold. Lost or stale flags and mask bits show as an irq_o level that is wrong in the cycle after the causing compare, read or mask write. A waveform action tied to the wrong compare moves the edge of wave_o by a whole compare interval, and the long free-running run exposes this over a full wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      ADR_MODE = 3'd0,
      ADR_CMPA = 3'd1,
      ADR_CMPC = 3'd2,
      ADR_CNT  = 3'd3,
      ADR_CMD  = 3'd4,
      ADR_IEN  = 3'd5,
      ADR_IDIS = 3'd6,
      ADR_STAT = 3'd7
   } tmr_addr_e;

   // mode word, low bits first: clock select, restart, halt, A sets, C clears
   typedef struct packed {
      logic       c_clr_out;
      logic       a_set_out;
      logic       halt_on_c;
      logic       restart_on_c;
      logic [1:0] clk_sel;
   } tmr_mode_t;

   localparam int unsigned CMD_EN_BIT   = 0;
   localparam int unsigned CMD_DIS_BIT  = 1;
   localparam int unsigned CMD_TRIG_BIT = 2;
   localparam int unsigned NUM_SRC      = 2;
   localparam int unsigned STAT_W       = NUM_SRC + 2;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int unsigned DIV_STEP    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart_i,
   input  logic [1:0] sel_i,
   input  logic       ext_clk_i,
   output logic       tick_o
);
   localparam int unsigned PRE_W = 2 * DIV_STEP;

   generate
      if (DIV_STEP < 1) begin : g_bad_step
         $error("DIV_STEP must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PRE_W-1:0]     pre_q;
   logic [SYNC_STAGES:0] sync_q;
   logic [3:0]           tick_opt;
   logic                 ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q <= '0;
      else if (restart_i) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
   end

   assign ext_rise    = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
   assign tick_opt[0] = 1'b1;
   assign tick_opt[3] = ext_rise;

   for (genvar k = 1; k < 3; k++) begin : g_div
      assign tick_opt[k] = &pre_q[k*DIV_STEP-1:0];
   end

   assign tick_o = tick_opt[sel_i];

   p_pre_restart_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (pre_q == '0));

   p_ext_single_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             dis_i,
   input  logic             trig_i,
   input  logic             restart_on_c_i,
   input  logic             halt_on_c_i,
   input  logic [CNT_W-1:0] cmp_a_i,
   input  logic [CNT_W-1:0] cmp_c_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             ev_a_o,
   output logic             ev_c_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             run_q;
   logic             step;

   assign step    = run_q & tick_i & ~trig_i;
   assign cnt_inc = (restart_on_c_i && (cnt_q == cmp_c_i)) ? '0 : cnt_q + 1'b1;
   assign ev_a_o  = step & (cnt_inc == cmp_a_i);
   assign ev_c_o  = step & (cnt_inc == cmp_c_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (trig_i) cnt_q <= '0;
      else if (step)   cnt_q <= cnt_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         run_q <= 1'b0;
      else if (dis_i)                     run_q <= 1'b0;
      else if (en_i)                      run_q <= 1'b1;
      else if (ev_c_o && halt_on_c_i)     run_q <= 1'b0;
   end

   assign cnt_o = cnt_q;
   assign run_o = run_q;

   p_freerun_wrap_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart_on_c_i && (&cnt_q)) |=> (cnt_q == '0));

   p_restart_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && restart_on_c_i && (cnt_q == cmp_c_i)) |=> (cnt_q == '0));

   p_halt_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_c_o && halt_on_c_i && !en_i) |=> !run_q);

   p_trig_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> (cnt_q == '0));

   p_dis_prio_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> !run_q);

   p_idle_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !trig_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
   import tmr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_a_i,
   input  logic               ev_c_i,
   input  logic               a_set_i,
   input  logic               c_clr_i,
   input  logic               ien_wr_i,
   input  logic               idis_wr_i,
   input  logic [NUM_SRC-1:0] mask_data_i,
   input  logic               stat_rd_i,
   output logic [NUM_SRC-1:0] flags_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               irq_o,
   output logic               wave_o
);
   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] set_bits;
   logic [NUM_SRC-1:0] clr_bits;
   logic               wave_q;

   assign set_bits = ien_wr_i  ? mask_data_i : '0;
   assign clr_bits = idis_wr_i ? mask_data_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         mask_q  <= '0;
      end else begin
         flags_q <= (stat_rd_i ? '0 : flags_q) | {ev_c_i, ev_a_i};
         mask_q  <= (mask_q | set_bits) & ~clr_bits;
      end
   end

   // a clearing C compare overrides a setting A compare in the same tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   wave_q <= 1'b0;
      else if (ev_c_i && c_clr_i)   wave_q <= 1'b0;
      else if (ev_a_i && a_set_i)   wave_q <= 1'b1;
   end

   assign flags_o = flags_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(flags_q & mask_q);
   assign wave_o  = wave_q;

   p_mask_all_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (idis_wr_i && !ien_wr_i && (&mask_data_i)) |=> !irq_o);

   p_rd_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !ev_a_i && !ev_c_i) |=> (flags_o == '0));

   p_keep_event_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_c_i |=> flags_o[1]);

   p_wave_rise_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wave_o) |-> $past(ev_a_i && a_set_i));

   p_wave_fall_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wave_o) |-> $past(ev_c_i && c_clr_i));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DIV_STEP    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr_i,
   input  logic             bus_rd_i,
   input  logic [2:0]       bus_addr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   input  logic             ext_clk_i,
   output logic             irq_o,
   output logic             wave_o
);
   localparam int unsigned MODE_W = $bits(tmr_mode_t);

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("CNT_W must be at least 8");
      end
   endgenerate

   tmr_addr_e          addr;
   tmr_mode_t          mode_q;
   logic [CNT_W-1:0]   cmp_a_q;
   logic [CNT_W-1:0]   cmp_c_q;
   logic [CNT_W-1:0]   cnt;
   logic               run;
   logic               ev_a;
   logic               ev_c;
   logic               tick;
   logic               cmd_wr;
   logic               cmd_en;
   logic               cmd_dis;
   logic               cmd_trig;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] mask;

   assign addr     = tmr_addr_e'(bus_addr_i);
   assign cmd_wr   = bus_wr_i && (addr == ADR_CMD);
   assign cmd_en   = cmd_wr && bus_wdata_i[CMD_EN_BIT];
   assign cmd_dis  = cmd_wr && bus_wdata_i[CMD_DIS_BIT];
   assign cmd_trig = cmd_wr && bus_wdata_i[CMD_TRIG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         cmp_a_q <= '0;
         cmp_c_q <= '0;
      end else if (bus_wr_i) begin
         case (addr)
            ADR_MODE: mode_q  <= tmr_mode_t'(bus_wdata_i[MODE_W-1:0]);
            ADR_CMPA: cmp_a_q <= bus_wdata_i;
            ADR_CMPC: cmp_c_q <= bus_wdata_i;
            default:  ;
         endcase
      end
   end

   tmr_tick_gen #(
      .DIV_STEP    (DIV_STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) tick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (cmd_trig),
      .sel_i     (mode_q.clk_sel),
      .ext_clk_i (ext_clk_i),
      .tick_o    (tick)
   );

   tmr_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick),
      .en_i           (cmd_en),
      .dis_i          (cmd_dis),
      .trig_i         (cmd_trig),
      .restart_on_c_i (mode_q.restart_on_c),
      .halt_on_c_i    (mode_q.halt_on_c),
      .cmp_a_i        (cmp_a_q),
      .cmp_c_i        (cmp_c_q),
      .cnt_o          (cnt),
      .run_o          (run),
      .ev_a_o         (ev_a),
      .ev_c_o         (ev_c)
   );

   tmr_evt_unit evt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_a_i      (ev_a),
      .ev_c_i      (ev_c),
      .a_set_i     (mode_q.a_set_out),
      .c_clr_i     (mode_q.c_clr_out),
      .ien_wr_i    (bus_wr_i && (addr == ADR_IEN)),
      .idis_wr_i   (bus_wr_i && (addr == ADR_IDIS)),
      .mask_data_i (bus_wdata_i[NUM_SRC-1:0]),
      .stat_rd_i   (bus_rd_i && (addr == ADR_STAT)),
      .flags_o     (flags),
      .mask_o      (mask),
      .irq_o       (irq_o),
      .wave_o      (wave_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (addr)
         ADR_MODE: bus_rdata_o[MODE_W-1:0] = mode_q;
         ADR_CMPA: bus_rdata_o = cmp_a_q;
         ADR_CMPC: bus_rdata_o = cmp_c_q;
         ADR_CNT:  bus_rdata_o = cnt;
         ADR_IEN:  bus_rdata_o[NUM_SRC-1:0] = mask;
         ADR_STAT: bus_rdata_o[STAT_W-1:0] = {wave_o, run, flags};
         default:  ;
      endcase
   end

   p_irq_needs_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags != '0));

   p_halted_holds_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cmd_wr) |=> !run);

endmodule

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;

   localparam int A_MODE = 0, A_CMPA = 1, A_CMPC = 2, A_CNT = 3,
                  A_CMD = 4, A_IEN = 5, A_IDIS = 6, A_STAT = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ext_clk = 1'b0;
   logic        irq;
   logic        wave;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr_chan dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .ext_clk_i   (ext_clk),
      .irq_o       (irq),
      .wave_o      (wave)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[15:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input int a, output int d);
      bus_addr = a[2:0];
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic rd_stat(output int d);
      bus_rd = 1'b1; bus_addr = 3'(A_STAT);
      #1;
      d = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int auto_count(input int m, input int c);
      return m % (c + 1);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int d;
      int seed;
      seed = 17;
      void'($urandom(seed));
      step(4);
      rst_n = 1'b1;
      step(1);

      // R11 reset state
      peek(A_CNT, d);  chk("R11 count after reset", d, 0);
      peek(A_STAT, d); chk("R11 status after reset", d, 0);
      chk("R11 irq after reset", int'(irq), 0);
      chk("R11 wave after reset", int'(wave), 0);

      // R1 / R7 free run square wave
      wr(A_MODE, 'h30); wr(A_CMPA, 0); wr(A_CMPC, 'h8000); wr(A_IEN, 1);
      wr(A_CMD, 5);
      peek(A_STAT, d); chk("R9 no compare on trigger zeroing", d, 4);
      step(32768);
      peek(A_CNT, d); chk("R11 live count at half", d, 'h8000);
      chk("R7 wave low after C compare", int'(wave), 0);
      step(1);
      peek(A_CNT, d); chk("R1 count passes C in free run", d, 'h8001);
      step(32767);
      peek(A_CNT, d); chk("R1 wrap to zero", d, 0);
      chk("R7 wave high at wrap", int'(wave), 1);
      chk("R6 irq on unmasked A flag", int'(irq), 1);
      step(32767);
      chk("R7 wave high through lower half", int'(wave), 1);
      step(1);
      chk("R7 wave falls at 0x8000", int'(wave), 0);
      wr(A_CMD, 2);
      rd_stat(d);
      wr(A_IDIS, 'hFF);

      // R2 restart on C
      wr(A_MODE, 'h04); wr(A_CMPC, 4); wr(A_CMD, 5);
      step(4); peek(A_CNT, d); chk("R2 reaches C", d, 4);
      step(1); peek(A_CNT, d); chk("R2 returns to zero", d, 0);
      step(2); peek(A_CNT, d); chk("R2 second period", d, 2);
      peek(A_STAT, d); chk("R2 C flag set", d & 2, 2);
      for (int i = 0; i < 8; i++) begin
         int c;
         int m;
         c = 1 + int'($urandom % 40);
         m = int'($urandom % 150);
         wr(A_CMPC, c); wr(A_CMD, 5);
         step(m);
         peek(A_CNT, d); chk("R2 random period", d, auto_count(m, c));
      end

      // R3 one shot
      wr(A_MODE, 'h08); wr(A_CMPC, 10); rd_stat(d); wr(A_IEN, 2);
      wr(A_CMD, 5);
      step(10); peek(A_CNT, d); chk("R3 reaches C", d, 10);
      step(10); peek(A_CNT, d); chk("R3 holds at C", d, 10);
      peek(A_STAT, d); chk("R3 flag set and stopped", d & 6, 2);
      chk("R6 irq on unmasked C flag", int'(irq), 1);

      // R4 trigger
      wr(A_CMD, 4);
      peek(A_CNT, d); chk("R4 trigger zeroes", d, 0);
      step(5); peek(A_CNT, d); chk("R4 trigger alone keeps stopped", d, 0);
      wr(A_CMD, 5);
      step(3); peek(A_CNT, d); chk("R4 trigger with enable starts", d, 3);

      // R5 disable priority
      wr(A_CMD, 3);
      step(5); peek(A_CNT, d); chk("R5 disable wins over enable", d, 4);
      peek(A_STAT, d); chk("R5 not running", d & 4, 0);
      wr(A_CMD, 1);
      step(2); peek(A_CNT, d); chk("R5 enable resumes", d, 6);

      // R6 masking
      wr(A_IDIS, 'hFF);
      chk("R6 mask all drops irq", int'(irq), 0);
      peek(A_STAT, d); chk("R6 flag kept while masked", d & 2, 2);
      wr(A_IEN, 2);
      chk("R6 unmask restores irq", int'(irq), 1);

      // R8 read clear
      rd_stat(d); chk("R8 read returns flag", d & 2, 2);
      peek(A_STAT, d); chk("R8 flags cleared", d & 3, 0);
      chk("R8 irq cleared", int'(irq), 0);
      wr(A_MODE, 'h04); wr(A_CMPC, 3); wr(A_CMD, 5);
      step(6);
      rd_stat(d);
      peek(A_STAT, d); chk("R8 same-cycle compare kept", d & 2, 2);
      chk("R8 irq from kept compare", int'(irq), 1);
      rd_stat(d);
      peek(A_STAT, d); chk("R8 cleared when no compare", d & 2, 0);

      // R9 C write applies on next tick
      wr(A_MODE, 0); wr(A_CMPC, 60); wr(A_CMD, 2); rd_stat(d);
      wr(A_CMD, 5);
      step(2);
      wr(A_CMPC, 6);
      step(2); peek(A_CNT, d); chk("R9 count before new C", d, 5);
      peek(A_STAT, d); chk("R9 no C flag yet", d & 2, 0);
      step(1); peek(A_STAT, d); chk("R9 new C compares", d & 2, 2);

      // R10 prescaled and external clocks
      wr(A_MODE, 1); wr(A_CMD, 5);
      step(3); peek(A_CNT, d); chk("R10 div4 before tick", d, 0);
      step(1); peek(A_CNT, d); chk("R10 div4 first tick", d, 1);
      step(5); peek(A_CNT, d); chk("R10 div4 second tick", d, 2);
      wr(A_MODE, 2); wr(A_CMD, 5);
      step(15); peek(A_CNT, d); chk("R10 div16 before tick", d, 0);
      step(1); peek(A_CNT, d); chk("R10 div16 first tick", d, 1);
      wr(A_MODE, 3); wr(A_CMD, 5);
      step(10); peek(A_CNT, d); chk("R10 external idle", d, 0);
      for (int p = 0; p < 3; p++) begin
         ext_clk = 1'b1; step(3);
         ext_clk = 1'b0; step(3);
      end
      step(4); peek(A_CNT, d); chk("R10 external edges counted", d, 3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule